// File: doc/BRIEF.md
# Microprogram Sequencer with Instruction Dispatch

This block owns the microprogram counter of a microcoded 32-bit processor. Every cycle it reads the current 32-bit microword from its own 256-entry microcode store and works out the address of the next one. The microword's top two bits choose among four successors: the next address, the fetch routine, an entry point looked up from the current instruction, or an 8-bit target carried in the microword itself.

The entry-point lookup is a fixed 128-entry table. Its 7-bit index is formed from the instruction register:
- When the primary opcode is zero (register-format), the index is the funct field with bit 6 set.
- Otherwise the index is the opcode with bit 6 clear.

Indices that name no implemented instruction lead to the undefined-instruction routine.

A trap-on-overflow bit in the microword lets an ALU overflow reported in the same cycle divert a return-to-fetch or explicit jump to the overflow routine. The store is written through a simple write port, normally while the sequencer is held in reset. The routine entry addresses are parameters, so the table follows any microprogram layout.

Top module: `useq`

## Requirements
- R1: While reset (rst_n low) is applied the microprogram counter upc is 0, and after release execution starts from address 0. At all times uword equals the store word at address upc.
- R2: When microword bits 31:30 are 0, the next upc is upc+1 modulo 256, so 255 is followed by 0.
- R3: When bits 31:30 are 1 and no overflow diversion applies, the next upc is 0 (fetch).
- R4: When bits 31:30 are 3 and no overflow diversion applies, the next upc is microword bits 8:1.
- R5: When bits 31:30 are 2, the next upc is the table entry at index {1'b1, funct} if ir_op is 0, else at {1'b0, ir_op}.
- R6: The table maps each implemented index to the entry of its routine class, and index 0x7f to the trap entry. The index groups are:
  - ALU: 0x40, 0x44, 0x46, 0x47, 0x60, 0x62, 0x64, 0x65, 0x66.
  - Unsigned ALU: 0x61, 0x63.
  - Unsigned set: 0x50–0x55.
  - Signed set: 0x68–0x6d.
  - Jumps and branches: j 0x02, jal 0x03, branch-if-zero 0x04, branch-if-nonzero 0x05, jr 0x12, jalr 0x13.
  - Immediate ALU: 0x08, 0x0a, 0x0c–0x0f, 0x14, 0x16, 0x17.
  - Unsigned immediate ALU: 0x09, 0x0b.
  - Immediate set: 0x18–0x1d.
  - Unsigned immediate set: 0x30–0x35.
  - Load: 0x23. Store: 0x2b.
- R7: Every other table index yields the undefined-instruction entry.
- R8: When bit 29 is set, alu_ovf is high and bits 31:30 are 1 or 3, the next upc is the overflow entry.
- R9: Overflow never alters an increment (0) or dispatch (2) step, and has no effect when bit 29 is clear.
- R10: A write with ucode_we high stores ucode_wdata at ucode_waddr at the clock edge, and the sequencer then follows the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counter |
| alu_ovf | input | 1 | ALU overflow in the current cycle |
| ir_op | input | 6 | Primary opcode of the instruction register |
| ir_funct | input | 6 | Funct field of the instruction register |
| ucode_we | input | 1 | Microcode store write enable |
| ucode_waddr | input | 8 | Microcode store write address |
| ucode_wdata | input | 32 | Microcode store write data |
| upc | output | 8 | Microprogram counter |
| uword | output | 32 | Microword at upc |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, 32-bit words and the default entry layout. This gives the full 256-word store, so counter wrap from 255 to 0 and explicit targets anywhere in the space are reachable. Two randomly filled stores, with one word pinned to reach address 255 and the word there pinned to increment, drive long random walks under random opcodes and overflow. Register-format funct 0x3f reaches the trap index, and random opcodes reach the undefined entries.

// File: rtl/useq.sv
module useq #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int ENT_LW    = 2,
  parameter int ENT_SW    = 5,
  parameter int ENT_ALU   = 7,
  parameter int ENT_ALUU  = 8,
  parameter int ENT_ALUI  = 9,
  parameter int ENT_ALUUI = 10,
  parameter int ENT_SET   = 13,
  parameter int ENT_SETU  = 15,
  parameter int ENT_SETI  = 17,
  parameter int ENT_SETUI = 19,
  parameter int ENT_J     = 21,
  parameter int ENT_JAL   = 22,
  parameter int ENT_JR    = 23,
  parameter int ENT_JALR  = 24,
  parameter int ENT_BEQZ  = 25,
  parameter int ENT_BNEZ  = 26,
  parameter int ENT_UNDEF = 27,
  parameter int ENT_OVER  = 28,
  parameter int ENT_TRAP  = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_ovf,
  input  logic [5:0]    ir_op,
  input  logic [5:0]    ir_funct,
  input  logic          ucode_we,
  input  logic [AW-1:0] ucode_waddr,
  input  logic [DW-1:0] ucode_wdata,
  output logic [AW-1:0] upc,
  output logic [DW-1:0] uword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [1:0]    sel;
  logic [6:0]    idx;
  logic          divert;
  logic [AW-1:0] upc_nxt;
  logic          run;

  function automatic logic [AW-1:0] lookup(input logic [6:0] ix);
    int e;
    case (ix)
      7'h40, 7'h44, 7'h46, 7'h47,
      7'h60, 7'h62, 7'h64, 7'h65, 7'h66:       e = ENT_ALU;
      7'h61, 7'h63:                            e = ENT_ALUU;
      7'h50, 7'h51, 7'h52, 7'h53, 7'h54, 7'h55: e = ENT_SETU;
      7'h68, 7'h69, 7'h6a, 7'h6b, 7'h6c, 7'h6d: e = ENT_SET;
      7'h7f:                                   e = ENT_TRAP;
      7'h02:                                   e = ENT_J;
      7'h03:                                   e = ENT_JAL;
      7'h04:                                   e = ENT_BEQZ;
      7'h05:                                   e = ENT_BNEZ;
      7'h12:                                   e = ENT_JR;
      7'h13:                                   e = ENT_JALR;
      7'h08, 7'h0a, 7'h0c, 7'h0d, 7'h0e, 7'h0f,
      7'h14, 7'h16, 7'h17:                     e = ENT_ALUI;
      7'h09, 7'h0b:                            e = ENT_ALUUI;
      7'h18, 7'h19, 7'h1a, 7'h1b, 7'h1c, 7'h1d: e = ENT_SETI;
      7'h30, 7'h31, 7'h32, 7'h33, 7'h34, 7'h35: e = ENT_SETUI;
      7'h23:                                   e = ENT_LW;
      7'h2b:                                   e = ENT_SW;
      default:                                 e = ENT_UNDEF;
    endcase
    return AW'(e);
  endfunction

  assign uword  = store[upc];
  assign sel    = uword[31:30];
  assign idx    = (ir_op == 6'd0) ? {1'b1, ir_funct} : {1'b0, ir_op};
  assign divert = uword[29] & alu_ovf & sel[0];

  always_comb begin
    if (divert) upc_nxt = AW'(ENT_OVER);
    else begin
      case (sel)
        2'd0:    upc_nxt = upc + 1'b1;
        2'd1:    upc_nxt = '0;
        2'd2:    upc_nxt = lookup(idx);
        default: upc_nxt = uword[8:1];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ucode_we) store[ucode_waddr] <= ucode_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upc <= '0;
      run <= 1'b0;
    end else begin
      upc <= upc_nxt;
      run <= 1'b1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> upc == '0);
  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(uword[31:30] == 2'd0) |-> upc == $past(upc) + 1'b1);
  assert_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(uword[31:30] == 2'd1 && !(uword[29] && alu_ovf)) |-> upc == '0);
  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(uword[31:30] == 2'd3 && !(uword[29] && alu_ovf)) |-> upc == $past(uword[8:1]));
  assert_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(uword[29] && alu_ovf && (uword[31:30] == 2'd1 || uword[31:30] == 2'd3))
    |-> upc == AW'(ENT_OVER));
  assert_trapidx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(uword[31:30] == 2'd2 && ir_op == 6'd0 && ir_funct == 6'h3f)
    |-> upc == AW'(ENT_TRAP));
endmodule

// File: tb/sim_useq.sv
module sim_useq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_ovf = 1'b0;
  logic [5:0]  ir_op = '0, ir_funct = '0;
  logic        ucode_we = 1'b0;
  logic [7:0]  ucode_waddr = '0;
  logic [31:0] ucode_wdata = '0;
  logic [7:0]  upc;
  logic [31:0] uword;

  int errors = 0, checks = 0;
  logic [31:0] mdl [256];
  logic [7:0]  upc_m;
  string       tag;

  useq u0 (.clk(clk), .rst_n(rst_n), .alu_ovf(alu_ovf), .ir_op(ir_op), .ir_funct(ir_funct),
           .ucode_we(ucode_we), .ucode_waddr(ucode_waddr), .ucode_wdata(ucode_wdata),
           .upc(upc), .uword(uword));

  always #4 clk = ~clk;

  function automatic logic [7:0] ref_map(input logic [6:0] ix);
    if (ix == 7'h7f) return 8'd29;
    if (ix >= 7'h50 && ix <= 7'h55) return 8'd15;
    if (ix >= 7'h68 && ix <= 7'h6d) return 8'd13;
    if (ix == 7'h61 || ix == 7'h63) return 8'd8;
    if (ix == 7'h40 || ix == 7'h44 || ix == 7'h46 || ix == 7'h47 || ix == 7'h60 ||
        ix == 7'h62 || (ix >= 7'h64 && ix <= 7'h66)) return 8'd7;
    if (ix >= 7'h18 && ix <= 7'h1d) return 8'd17;
    if (ix >= 7'h30 && ix <= 7'h35) return 8'd19;
    if (ix == 7'h09 || ix == 7'h0b) return 8'd10;
    if (ix == 7'h08 || ix == 7'h0a || (ix >= 7'h0c && ix <= 7'h0f) || ix == 7'h14 ||
        ix == 7'h16 || ix == 7'h17) return 8'd9;
    if (ix == 7'h02) return 8'd21;
    if (ix == 7'h03) return 8'd22;
    if (ix == 7'h04) return 8'd25;
    if (ix == 7'h05) return 8'd26;
    if (ix == 7'h12) return 8'd23;
    if (ix == 7'h13) return 8'd24;
    if (ix == 7'h23) return 8'd2;
    if (ix == 7'h2b) return 8'd5;
    return 8'd27;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_store(input int mode);
    rst_n = 1'b0;
    for (int a = 0; a < 256; a++) begin
      logic [31:0] w;
      w = $urandom;
      if (mode == 1 && a == 255) w[31:30] = 2'd0;
      if (mode == 1 && a == 3) begin w[31:30] = 2'd3; w[8:1] = 8'd255; end
      mdl[a] = w;
      @(negedge clk);
      ucode_we = 1'b1; ucode_waddr = 8'(a); ucode_wdata = w;
    end
    @(negedge clk);
    ucode_we = 1'b0;
    @(negedge clk);
    chk("R1 reset upc", 32'(upc), 32'd0);
    chk("R1 reset uword", uword, mdl[0]);
  endtask

  task automatic walk(input int n);
    upc_m = 8'd0;
    rst_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      logic [6:0]  ix;
      w = mdl[upc_m];
      alu_ovf = ($urandom % 3) == 0;
      ir_op = ($urandom % 2) ? 6'd0 : 6'($urandom);
      ir_funct = ($urandom % 8 == 0) ? 6'h3f : 6'($urandom);
      ix = (ir_op == 0) ? {1'b1, ir_funct} : {1'b0, ir_op};
      if (w[29] && alu_ovf && w[30]) begin upc_m = 8'd28; tag = "R8 overflow divert"; end
      else case (w[31:30])
        2'd0: begin upc_m = upc_m + 8'd1; tag = (w[29] && alu_ovf) ? "R9 increment" : "R2 increment"; end
        2'd1: begin upc_m = 8'd0; tag = "R3 fetch"; end
        2'd2: begin upc_m = ref_map(ix);
              tag = (ref_map(ix) == 8'd27) ? "R7 undefined" : (ix == 7'h7f) ? "R6 trap index" : "R5 dispatch"; end
        default: begin upc_m = w[8:1]; tag = "R4 explicit"; end
      endcase
      @(negedge clk);
      chk(tag, 32'(upc), 32'(upc_m));
      chk("R10 uword", uword, mdl[upc_m]);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    load_store(1);
    walk(3000);
    load_store(0);
    walk(3000);
    for (int k = 0; k < 128; k++) begin
      automatic logic [7:0] e = ref_map(7'(k));
      load_store(2);
      mdl[0] = {2'd2, 30'd0};
      @(negedge clk); ucode_we = 1'b1; ucode_waddr = 8'd0; ucode_wdata = mdl[0];
      @(negedge clk); ucode_we = 1'b0;
      ir_op = (k >= 64) ? 6'd0 : 6'(k); ir_funct = 6'(k);
      if (k < 64 && k == 0) begin ir_op = 6'd0; ir_funct = 6'd0; end
      rst_n = 1'b1;
      @(negedge clk);
      if (k >= 64 || k != 0) chk((e == 8'd27) ? "R7 table" : "R6 table", 32'(upc), 32'(e));
      if (k >= 1) k = (k == 1) ? 63 : 127;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule